// File: doc/BRIEF.md
# Processor exception entry controller

This block sits beside a processor pipeline and performs the state side of taking an exception. When the pipeline raises a general exception or a debug exception, the block updates the privileged save registers and the processor status word on one clock edge. One cycle later it pulses a redirect strobe with a vector identifier, which the fetch logic turns into an address.

A general exception is a double exception when the status word already has its exception-mode flag set. A double exception is steered to the double-exception PC register when the build has one, and otherwise to the level-1 exception PC register. A first-level exception goes to the user or kernel vector, chosen by the user-mode flag. The general request can also carry a faulting virtual address.

A debug request is taken only when the current interrupt level is below the configured debug level. On entry the block saves the PC and the old status word for that level, forces the interrupt level to the debug level and enters exception mode. The pipeline's own writes to the status word come in through a separate write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, every save register and the status word read zero, and `redirect_o` is low.
- R2: A general entry while status bit 4 (exception mode) is clear writes the request PC to `epc1_o`. The vector is 1 (user) when status bit 5 is set and 0 (kernel) otherwise.
- R3: A general entry while status bit 4 is set gives vector 2 (double). The PC goes to `depc_o` when HAS_DEPC is 1, and `epc1_o` keeps its value. With HAS_DEPC at 0 the PC goes to `epc1_o`.
- R4: Every general entry loads `cause_i` into `cause_o` and sets status bit 4. All other status bits keep their values.
- R5: A general entry with `addr_valid_i` high loads `fault_va_i` into `va_o`. Without that flag, `va_o` keeps its value.
- R6: A debug request is accepted only when status bits 3:0 (interrupt level) are strictly below DBG_LEVEL. A rejected debug request alone changes no register and gives no redirect.
- R7: A debug entry loads `dbg_cause_o`, writes the PC to `dbg_epc_o` and the old status word to `dbg_eps_o`, and gives vector 3. It sets status bits 3:0 to DBG_LEVEL and sets bit 4, keeps the other status bits, and leaves `epc1_o`, `depc_o`, `cause_o` and `va_o` unchanged.
- R8: When a general request and an accepted debug request arrive in the same cycle, only the debug entry is taken. A debug request that fails the level gate lets a general request in the same cycle proceed.
- R9: `redirect_o` pulses high for exactly the cycle after each accepted entry, with `vector_o` valid in that cycle.
- R10: A status write through `st_we_i` takes effect on the next edge when no entry is accepted. It is ignored in a cycle in which an entry is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 1 | General exception request, one-cycle strobe |
| dbg_raise_i | input | 1 | Debug exception request, one-cycle strobe |
| addr_valid_i | input | 1 | General request carries a faulting virtual address |
| fault_pc_i | input | XLEN | PC of the faulting instruction |
| cause_i | input | CAUSE_W | General cause code |
| fault_va_i | input | XLEN | Faulting virtual address |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| st_we_i | input | 1 | Status word write enable |
| st_wdata_i | input | 16 | Status word write data |
| status_o | output | 16 | Status word |
| epc1_o | output | XLEN | Level-1 exception PC |
| depc_o | output | XLEN | Double-exception PC (zero when HAS_DEPC is 0) |
| cause_o | output | CAUSE_W | Exception cause |
| va_o | output | XLEN | Faulting virtual address |
| dbg_cause_o | output | DCAUSE_W | Debug cause |
| dbg_epc_o | output | XLEN | Saved PC for the debug level |
| dbg_eps_o | output | 16 | Saved status for the debug level |
| redirect_o | output | 1 | Redirect strobe, one cycle after an entry |
| vector_o | output | 2 | Vector identifier: 0 kernel, 1 user, 2 double, 3 debug |

## Verification
The assertions assume that requests and status writes are clean one-cycle values sampled on the clock edge. They also assume DBG_LEVEL lies between 2 and 7, so it fits the interrupt-level field. The stimulus drives every input at the falling edge and holds it for exactly one rising edge. It sweeps all 64 combinations of interrupt level, exception mode and user mode against four request kinds, with fixed upper status bits so that preservation is visible. A second instance built without the double-exception PC register receives the same stimulus.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int ST_W     = 16;
  localparam int ILVL_W   = 4;
  localparam int EXM_BIT  = 4;
  localparam int UM_BIT   = 5;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  typedef struct packed {
    logic take_gen;
    logic take_dbg;
    logic dbl;
    vec_e vec;
  } entry_t;
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
#(
  parameter int DBG_LEVEL = 6
) (
  input  logic            raise,
  input  logic            dbg_raise,
  input  logic [ST_W-1:0] status,
  output entry_t          sel
);
  localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DBG_LEVEL);

  logic gate_ok;

  always_comb begin
    gate_ok      = status[ILVL_W-1:0] < DBG_LVL;
    sel.take_dbg = dbg_raise && gate_ok;
    sel.take_gen = raise && !sel.take_dbg;
    sel.dbl      = status[EXM_BIT];
    if (sel.take_dbg)
      sel.vec = VEC_DEBUG;
    else if (status[EXM_BIT])
      sel.vec = VEC_DOUBLE;
    else if (status[UM_BIT])
      sel.vec = VEC_USER;
    else
      sel.vec = VEC_KERNEL;
  end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
#(
  parameter int DBG_LEVEL = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  entry_t          sel,
  input  logic            we,
  input  logic [ST_W-1:0] wdata,
  output logic [ST_W-1:0] status
);
  localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DBG_LEVEL);

  logic [ST_W-1:0] nxt;

  always_comb begin
    nxt = status;
    if (sel.take_dbg) begin
      nxt[ILVL_W-1:0] = DBG_LVL;
      nxt[EXM_BIT]    = 1'b1;
    end else if (sel.take_gen) begin
      nxt[EXM_BIT]    = 1'b1;
    end else if (we) begin
      nxt = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= nxt;
  end

  a_r4_exm_set: assert property (@(posedge clk) disable iff (rst)
    (sel.take_gen || sel.take_dbg) |=> status[EXM_BIT]);
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
    sel.take_gen |=> status[ST_W-1:UM_BIT] == $past(status[ST_W-1:UM_BIT]));
  a_r7_level_forced: assert property (@(posedge clk) disable iff (rst)
    sel.take_dbg |=> status[ILVL_W-1:0] == DBG_LVL);
  a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && !sel.take_gen && !sel.take_dbg) |=> status == $past(wdata));
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  entry_t              sel,
  input  logic                addr_valid,
  input  logic [XLEN-1:0]     pc,
  input  logic [CAUSE_W-1:0]  cause,
  input  logic [XLEN-1:0]     va,
  input  logic [DCAUSE_W-1:0] dcause,
  input  logic [ST_W-1:0]     status,
  output logic [XLEN-1:0]     epc1,
  output logic [XLEN-1:0]     depc,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [XLEN-1:0]     va_q,
  output logic [DCAUSE_W-1:0] dcause_q,
  output logic [XLEN-1:0]     dbg_epc,
  output logic [ST_W-1:0]     dbg_eps
);
  logic to_depc;
  logic to_epc1;

  assign to_depc = sel.take_gen && sel.dbl && HAS_DEPC;
  assign to_epc1 = sel.take_gen && !to_depc;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc1     <= '0;
      cause_q  <= '0;
      va_q     <= '0;
      dcause_q <= '0;
      dbg_epc  <= '0;
      dbg_eps  <= '0;
    end else begin
      if (to_epc1)                   epc1    <= pc;
      if (sel.take_gen)              cause_q <= cause;
      if (sel.take_gen && addr_valid) va_q   <= va;
      if (sel.take_dbg) begin
        dcause_q <= dcause;
        dbg_epc  <= pc;
        dbg_eps  <= status;
      end
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk) begin
        if (rst)          depc_q <= '0;
        else if (to_depc) depc_q <= pc;
      end
      assign depc = depc_q;

      a_r3_depc_capture: assert property (@(posedge clk) disable iff (rst)
        (sel.take_gen && sel.dbl) |=> (depc == $past(pc)) && $stable(epc1));
    end else begin : g_no_depc
      assign depc = '0;

      a_r3_epc1_double: assert property (@(posedge clk) disable iff (rst)
        (sel.take_gen && sel.dbl) |=> epc1 == $past(pc));
    end
  endgenerate

  a_r4_cause_loaded: assert property (@(posedge clk) disable iff (rst)
    sel.take_gen |=> cause_q == $past(cause));
  a_r5_va_hold: assert property (@(posedge clk) disable iff (rst)
    !(sel.take_gen && addr_valid) |=> $stable(va_q));
  a_r7_eps_capture: assert property (@(posedge clk) disable iff (rst)
    sel.take_dbg |=> (dbg_eps == $past(status)) && (dbg_epc == $past(pc)));
  a_r7_general_untouched: assert property (@(posedge clk) disable iff (rst)
    sel.take_dbg |=> $stable(epc1) && $stable(cause_q) && $stable(va_q));
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  entry_t     sel,
  output logic       redirect,
  output logic [1:0] vector
);
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect <= 1'b0;
      vector   <= VEC_KERNEL;
    end else begin
      redirect <= sel.take_gen || sel.take_dbg;
      if (sel.take_gen || sel.take_dbg) vector <= sel.vec;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DCAUSE_W  = 6,
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                raise_i,
  input  logic                dbg_raise_i,
  input  logic                addr_valid_i,
  input  logic [XLEN-1:0]     fault_pc_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [XLEN-1:0]     fault_va_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic                st_we_i,
  input  logic [15:0]         st_wdata_i,
  output logic [15:0]         status_o,
  output logic [XLEN-1:0]     epc1_o,
  output logic [XLEN-1:0]     depc_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [XLEN-1:0]     va_o,
  output logic [DCAUSE_W-1:0] dbg_cause_o,
  output logic [XLEN-1:0]     dbg_epc_o,
  output logic [15:0]         dbg_eps_o,
  output logic                redirect_o,
  output logic [1:0]          vector_o
);
  localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DBG_LEVEL);

  entry_t sel;

  exc_select #(.DBG_LEVEL(DBG_LEVEL)) u_sel (
    .raise(raise_i), .dbg_raise(dbg_raise_i), .status(status_o), .sel(sel)
  );

  exc_status_reg #(.DBG_LEVEL(DBG_LEVEL)) u_st (
    .clk(clk), .rst(rst), .sel(sel), .we(st_we_i), .wdata(st_wdata_i),
    .status(status_o)
  );

  exc_save_bank #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .HAS_DEPC(HAS_DEPC)
  ) u_bank (
    .clk(clk), .rst(rst), .sel(sel), .addr_valid(addr_valid_i),
    .pc(fault_pc_i), .cause(cause_i), .va(fault_va_i), .dcause(dbg_cause_i),
    .status(status_o), .epc1(epc1_o), .depc(depc_o), .cause_q(cause_o),
    .va_q(va_o), .dcause_q(dbg_cause_o), .dbg_epc(dbg_epc_o),
    .dbg_eps(dbg_eps_o)
  );

  exc_redirect u_redir (
    .clk(clk), .rst(rst), .sel(sel), .redirect(redirect_o), .vector(vector_o)
  );

  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && vector_o == 2'd3) |-> $past(status_o[ILVL_W-1:0]) < DBG_LVL);
  a_r6_rejected_quiet: assert property (@(posedge clk) disable iff (rst)
    (dbg_raise_i && !raise_i && status_o[ILVL_W-1:0] >= DBG_LVL) |=> !redirect_o);
  a_r8_debug_wins: assert property (@(posedge clk) disable iff (rst)
    (dbg_raise_i && raise_i && status_o[ILVL_W-1:0] < DBG_LVL)
      |=> $stable(cause_o) && vector_o == 2'd3);
  a_r9_redirect_source: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> $past(raise_i || dbg_raise_i));
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int DBG = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise_i = 0, dbg_raise_i = 0, addr_valid_i = 0, st_we_i = 0;
  logic [31:0] fault_pc_i = 0, fault_va_i = 0;
  logic [5:0]  cause_i = 0, dbg_cause_i = 0;
  logic [15:0] st_wdata_i = 0;

  logic [15:0] status_o, dbg_eps_o, status_b, dbg_eps_b;
  logic [31:0] epc1_o, depc_o, va_o, dbg_epc_o, epc1_b, depc_b, va_b, dbg_epc_b;
  logic [5:0]  cause_o, dbg_cause_o, cause_b, dbg_cause_b;
  logic        redirect_o, redirect_b;
  logic [1:0]  vector_o, vector_b;

  always #2 clk = ~clk;

  exc_entry_ctrl #(.DBG_LEVEL(DBG), .HAS_DEPC(1'b1)) uut (
    .clk(clk), .rst(rst), .raise_i(raise_i), .dbg_raise_i(dbg_raise_i),
    .addr_valid_i(addr_valid_i), .fault_pc_i(fault_pc_i), .cause_i(cause_i),
    .fault_va_i(fault_va_i), .dbg_cause_i(dbg_cause_i), .st_we_i(st_we_i),
    .st_wdata_i(st_wdata_i), .status_o(status_o), .epc1_o(epc1_o),
    .depc_o(depc_o), .cause_o(cause_o), .va_o(va_o), .dbg_cause_o(dbg_cause_o),
    .dbg_epc_o(dbg_epc_o), .dbg_eps_o(dbg_eps_o), .redirect_o(redirect_o),
    .vector_o(vector_o)
  );

  exc_entry_ctrl #(.DBG_LEVEL(DBG), .HAS_DEPC(1'b0)) uut_nd (
    .clk(clk), .rst(rst), .raise_i(raise_i), .dbg_raise_i(dbg_raise_i),
    .addr_valid_i(addr_valid_i), .fault_pc_i(fault_pc_i), .cause_i(cause_i),
    .fault_va_i(fault_va_i), .dbg_cause_i(dbg_cause_i), .st_we_i(st_we_i),
    .st_wdata_i(st_wdata_i), .status_o(status_b), .epc1_o(epc1_b),
    .depc_o(depc_b), .cause_o(cause_b), .va_o(va_b), .dbg_cause_o(dbg_cause_b),
    .dbg_epc_o(dbg_epc_b), .dbg_eps_o(dbg_eps_b), .redirect_o(redirect_b),
    .vector_o(vector_b)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench-side model of the first instance
  logic [31:0] m_epc1, m_depc, m_va, m_depc_dbg, m_epc1_nd;
  logic [5:0]  m_cause, m_dcause;
  logic [15:0] m_eps;

  initial begin
    m_epc1 = 0; m_depc = 0; m_va = 0; m_depc_dbg = 0; m_epc1_nd = 0;
    m_cause = 0; m_dcause = 0; m_eps = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check("R1 status", {16'h0, status_o}, 0);
    check("R1 epc1", epc1_o, 0);
    check("R1 depc", depc_o, 0);
    check("R1 cause", {26'h0, cause_o}, 0);
    check("R1 va", va_o, 0);
    check("R1 dbg_epc", dbg_epc_o, 0);
    check("R1 dbg_eps", {16'h0, dbg_eps_o}, 0);
    check("R1 redirect", {31'h0, redirect_o}, 0);

    for (int s = 0; s < 64; s++) begin
      for (int mode = 0; mode < 4; mode++) begin
        logic [15:0] st, exp_st;
        logic [31:0] pc, va;
        logic [5:0]  cs, dc;
        logic        g, d, acc_d, acc_g, pass;
        logic [1:0]  evec;
        st = 16'hA500 | 16'(s);
        pc = 32'h4000_0000 + 32'(s * 16 + mode * 4);
        va = 32'hC000_0000 ^ 32'(s * 977 + mode);
        cs = 6'(s + mode + 1);
        dc = 6'(63 - s);
        g  = (mode != 2);
        d  = (mode >= 2);
        // R10 write lands when nothing else happens
        @(negedge clk);
        st_we_i = 1; st_wdata_i = st;
        @(negedge clk);
        st_we_i = 0;
        check("R10 write", {16'h0, status_o}, {16'h0, st});
        // raise cycle
        raise_i = g; dbg_raise_i = d; addr_valid_i = (mode == 1);
        fault_pc_i = pc; fault_va_i = va; cause_i = cs; dbg_cause_i = dc;
        st_we_i = (mode != 2); st_wdata_i = 16'hFFFF;
        pass  = (st[3:0] < 4'(DBG));
        acc_d = d && pass;
        acc_g = g && !acc_d;
        exp_st = st;
        evec = 0;
        if (acc_d) begin
          m_dcause = dc; m_depc_dbg = pc; m_eps = st;
          exp_st = (st & 16'hFFF0) | 16'h0010 | 16'(DBG);
          evec = 3;
        end else if (acc_g) begin
          if (mode == 1) m_va = va;
          m_cause = cs;
          if (st[4]) begin
            m_depc = pc; m_epc1_nd = pc; evec = 2;
          end else begin
            m_epc1 = pc; m_epc1_nd = pc; evec = st[5] ? 2'd1 : 2'd0;
          end
          exp_st = st | 16'h0010;
        end
        @(negedge clk);
        raise_i = 0; dbg_raise_i = 0; addr_valid_i = 0; st_we_i = 0;
        check("R2 epc1", epc1_o, m_epc1);
        check("R3 depc", depc_o, m_depc);
        check("R3 epc1 without depc", epc1_b, m_epc1_nd);
        check("R4 cause", {26'h0, cause_o}, {26'h0, m_cause});
        check("R4 R7 R10 status", {16'h0, status_o}, {16'h0, exp_st});
        check("R5 va", va_o, m_va);
        check("R7 dbg_cause", {26'h0, dbg_cause_o}, {26'h0, m_dcause});
        check("R7 dbg_epc", dbg_epc_o, m_depc_dbg);
        check("R7 dbg_eps", {16'h0, dbg_eps_o}, {16'h0, m_eps});
        check("R6 R9 redirect", {31'h0, redirect_o}, {31'h0, acc_d || acc_g});
        if (acc_d || acc_g) begin
          check("R2 R3 R7 R8 vector", {30'h0, vector_o}, {30'h0, evec});
          check("R9 vector without depc", {30'h0, vector_b}, {30'h0, evec});
        end
        @(negedge clk);
        check("R9 single pulse", {31'h0, redirect_o}, 0);
      end
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule